// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block takes one 16-bit compact-mode instruction word per cycle and turns it into a class code plus a fixed set of operand fields: destination register, source/base register, second register, a small operation selector and a 32-bit immediate. Downstream execution logic reads only these fields and never looks at the raw encoding, so the 16-bit front end can share one execution back end with a wider decoder.

Every bit of the word takes part in the decode. Some large groups lose a few sub-values to other classes: shift with op 3 becomes add/subtract, hi-register op 3 becomes branch-exchange, and condition 15 becomes a software interrupt. In the miscellaneous group only the stack-adjust and push/pop patterns are valid. Any word that matches no class decodes as Undefined, and all its fields are zero. Branch displacements leave the block already sign-extended and scaled to bytes.

The result is registered once. A word presented with `in_valid` high appears on the outputs after the next rising clock edge. While `in_valid` is low the decoded fields keep their last value.

Top module: `cdec16_top`

## Requirements
- R1: An active-low asynchronous reset clears `out_valid`, sets `out_cls` to 0 (Undefined) and clears `out_rd`, `out_rs`, `out_rm`, `out_op` and `out_imm`.
- R2: The outputs update one rising edge after the input. `out_valid` equals `in_valid` from the previous edge. When `in_valid` is low the decoded fields hold.
- R3: Bits 15:13 = 000 with bits 12:11 other than 3 give class 1 (shift): op = [12:11], imm = [10:6], rm = [5:3], rd = [2:0]. Bits 15:11 = 00011 give add/subtract with op = bit 9, rs = [5:3] and rd = [2:0]. Here bit 10 = 1 selects class 3 with imm = [8:6], and bit 10 = 0 selects class 2 with rm = [8:6].
- R4: Bits 15:13 = 001 give class 4: op = [12:11], rd = [10:8], imm = [7:0].
- R5: Bits 15:10 = 010000 give class 5: op = [9:6], rm = [5:3], rd = [2:0]. Bits 15:10 = 010001 with [9:8] not 3 give class 6: op = [9:8], rd = {bit 7, [2:0]}, rm = [6:3]. Upper byte 0x47 gives class 7 with only rm = [6:3].
- R6: Bits 15:11 = 01001 give class 8: rd = [10:8], imm = [7:0] times 4. Bits 15:12 = 0101 give class 9: op = [11:9], rm = [8:6], rs = [5:3], rd = [2:0].
- R7: Bits 15:13 = 011 give class 10 with op = [12:11]. Bits 15:12 = 1000 give class 11 with op = bit 11. Both take imm = [10:6], rs = [5:3], rd = [2:0]. Nibbles 1001 and 1010 give classes 12 and 13: op = bit 11, rd = [10:8], imm = [7:0].
- R8: Upper byte 0xB0 gives class 14: op = bit 7 (sign), imm = [6:0]. Bits 15:12 = 1011 with [10:9] = 10 give class 15: op = {bit 11, bit 8}, imm = [7:0]. Every other word with upper nibble 1011 is Undefined.
- R9: Bits 15:12 = 1100 give class 16: op = bit 11, rs = [10:8], imm = [7:0].
- R10: Upper nibble 1101 with condition [11:8] from 0 to 14 gives class 17: op = condition, imm = sign-extended [7:0] times 2. Condition 15 gives class 18 with imm = [7:0].
- R11: Bits 15:11 = 11100 give class 19 with imm = sign-extended [10:0] times 2. Bits 15:11 = 11101 are Undefined. Bits 15:11 = 11110 and 11111 give classes 20 and 21, with imm = [10:0] zero-extended.
- R12: For every class, each field that the class does not define is zero. An Undefined word (class 0) has every field zero. At most one class matches any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word is present |
| in_insn | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded fields are new this cycle |
| out_cls | output | 5 | Class code (0 = Undefined) |
| out_rd | output | 4 | Destination register |
| out_rs | output | 4 | Source or base register |
| out_rm | output | 4 | Second register operand |
| out_op | output | 4 | Operation or mode selector, or condition |
| out_imm | output | 32 | Immediate, offset, list or displacement |

## Verification
The hardest cases sit on the edges of carved-out regions. One is a word that differs from a valid class only in a sub-field value that has been taken away, such as 1011 0001 next to the stack adjust, 1101 1111 next to the conditional branch, or 11101 between the near branch and the long-branch halves. Random words rarely land exactly on these patterns. The vector table therefore places each excluded value directly beside a valid neighbour, and adds displacements with the top bit set so that sign extension is exercised. A directed sequence then drops `in_valid` while a different word is on the bus, which shows that the fields hold.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
  localparam int INSN_W = 16;
  localparam int CLS_W  = 5;
  localparam int REG_W  = 4;
  localparam int OP_W   = 4;
  localparam int NCLS   = 22;

  typedef enum logic [CLS_W-1:0] {
    CL_UNDEF    = 5'd0,
    CL_SHIFT    = 5'd1,
    CL_ADDS_REG = 5'd2,
    CL_ADDS_IMM = 5'd3,
    CL_IMM8     = 5'd4,
    CL_ALU      = 5'd5,
    CL_HIREG    = 5'd6,
    CL_BXCH     = 5'd7,
    CL_LITLD    = 5'd8,
    CL_REGOFS   = 5'd9,
    CL_IMMXFER  = 5'd10,
    CL_HALFXFER = 5'd11,
    CL_SPXFER   = 5'd12,
    CL_ADRGEN   = 5'd13,
    CL_SPADJ    = 5'd14,
    CL_STKLIST  = 5'd15,
    CL_MULTI    = 5'd16,
    CL_CBR      = 5'd17,
    CL_SWI      = 5'd18,
    CL_BR       = 5'd19,
    CL_LNK_HI   = 5'd20,
    CL_LNK_LO   = 5'd21
  } cls_e;
endpackage

// File: rtl/cdec_classify.sv
module cdec_classify
  import cdec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic [NCLS-1:0]   hits,
  output cls_e              cls
);
  always_comb begin
    hits = '0;
    hits[CL_SHIFT]    = (insn[15:13] == 3'b000) && (insn[12:11] != 2'b11);
    hits[CL_ADDS_REG] = (insn[15:11] == 5'b00011) && !insn[10];
    hits[CL_ADDS_IMM] = (insn[15:11] == 5'b00011) &&  insn[10];
    hits[CL_IMM8]     = (insn[15:13] == 3'b001);
    hits[CL_ALU]      = (insn[15:10] == 6'b010000);
    hits[CL_HIREG]    = (insn[15:10] == 6'b010001) && (insn[9:8] != 2'b11);
    hits[CL_BXCH]     = (insn[15:8]  == 8'h47);
    hits[CL_LITLD]    = (insn[15:11] == 5'b01001);
    hits[CL_REGOFS]   = (insn[15:12] == 4'b0101);
    hits[CL_IMMXFER]  = (insn[15:13] == 3'b011);
    hits[CL_HALFXFER] = (insn[15:12] == 4'b1000);
    hits[CL_SPXFER]   = (insn[15:12] == 4'b1001);
    hits[CL_ADRGEN]   = (insn[15:12] == 4'b1010);
    hits[CL_SPADJ]    = (insn[15:8]  == 8'hB0);
    hits[CL_STKLIST]  = (insn[15:12] == 4'b1011) && (insn[10:9] == 2'b10);
    hits[CL_MULTI]    = (insn[15:12] == 4'b1100);
    hits[CL_CBR]      = (insn[15:12] == 4'b1101) && (insn[11:8] != 4'hF);
    hits[CL_SWI]      = (insn[15:8]  == 8'hDF);
    hits[CL_BR]       = (insn[15:11] == 5'b11100);
    hits[CL_LNK_HI]   = (insn[15:11] == 5'b11110);
    hits[CL_LNK_LO]   = (insn[15:11] == 5'b11111);
  end

  always_comb begin
    cls = CL_UNDEF;
    for (int k = 1; k < NCLS; k++) begin
      if (hits[k]) cls = cls_e'(CLS_W'(k));
    end
  end
endmodule

// File: rtl/cdec_fields.sv
module cdec_fields
  import cdec_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  input  cls_e              cls,
  output logic [REG_W-1:0]  rd,
  output logic [REG_W-1:0]  rs,
  output logic [REG_W-1:0]  rm,
  output logic [OP_W-1:0]   op,
  output logic [IMM_W-1:0]  imm
);
  function automatic logic [IMM_W-1:0] f_zext(input logic [10:0] v);
    return IMM_W'(v);
  endfunction

  function automatic logic [IMM_W-1:0] f_disp8(input logic [7:0] d);
    return {{(IMM_W-9){d[7]}}, d, 1'b0};
  endfunction

  function automatic logic [IMM_W-1:0] f_disp11(input logic [10:0] d);
    return {{(IMM_W-12){d[10]}}, d, 1'b0};
  endfunction

  function automatic logic [REG_W-1:0] f_lo(input logic [2:0] r);
    return {1'b0, r};
  endfunction

  always_comb begin
    rd  = '0;
    rs  = '0;
    rm  = '0;
    op  = '0;
    imm = '0;
    unique case (cls)
      CL_SHIFT: begin
        op = OP_W'(insn[12:11]); imm = f_zext(11'(insn[10:6]));
        rm = f_lo(insn[5:3]);    rd  = f_lo(insn[2:0]);
      end
      CL_ADDS_REG: begin
        op = OP_W'(insn[9]); rm = f_lo(insn[8:6]);
        rs = f_lo(insn[5:3]); rd = f_lo(insn[2:0]);
      end
      CL_ADDS_IMM: begin
        op = OP_W'(insn[9]); imm = f_zext(11'(insn[8:6]));
        rs = f_lo(insn[5:3]); rd = f_lo(insn[2:0]);
      end
      CL_IMM8: begin
        op = OP_W'(insn[12:11]); rd = f_lo(insn[10:8]);
        imm = f_zext(11'(insn[7:0]));
      end
      CL_ALU: begin
        op = insn[9:6]; rm = f_lo(insn[5:3]); rd = f_lo(insn[2:0]);
      end
      CL_HIREG: begin
        op = OP_W'(insn[9:8]); rd = {insn[7], insn[2:0]}; rm = insn[6:3];
      end
      CL_BXCH: rm = insn[6:3];
      CL_LITLD: begin
        rd = f_lo(insn[10:8]); imm = f_zext({1'b0, insn[7:0], 2'b00});
      end
      CL_REGOFS: begin
        op = OP_W'(insn[11:9]); rm = f_lo(insn[8:6]);
        rs = f_lo(insn[5:3]);   rd = f_lo(insn[2:0]);
      end
      CL_IMMXFER, CL_HALFXFER: begin
        op  = (cls == CL_IMMXFER) ? OP_W'(insn[12:11]) : OP_W'(insn[11]);
        imm = f_zext(11'(insn[10:6]));
        rs  = f_lo(insn[5:3]); rd = f_lo(insn[2:0]);
      end
      CL_SPXFER, CL_ADRGEN: begin
        op = OP_W'(insn[11]); rd = f_lo(insn[10:8]);
        imm = f_zext(11'(insn[7:0]));
      end
      CL_SPADJ: begin
        op = OP_W'(insn[7]); imm = f_zext(11'(insn[6:0]));
      end
      CL_STKLIST: begin
        op = OP_W'({insn[11], insn[8]}); imm = f_zext(11'(insn[7:0]));
      end
      CL_MULTI: begin
        op = OP_W'(insn[11]); rs = f_lo(insn[10:8]);
        imm = f_zext(11'(insn[7:0]));
      end
      CL_CBR: begin
        op = insn[11:8]; imm = f_disp8(insn[7:0]);
      end
      CL_SWI:   imm = f_zext(11'(insn[7:0]));
      CL_BR:    imm = f_disp11(insn[10:0]);
      CL_LNK_HI, CL_LNK_LO: imm = f_zext(insn[10:0]);
      default: ;
    endcase
  end
endmodule

// File: rtl/cdec_pipe_reg.sv
module cdec_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_in,
  input  logic [W-1:0] din,
  output logic         vld_out,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_out <= 1'b0;
      dout    <= '0;
    end else begin
      vld_out <= vld_in;
      if (vld_in) dout <= din;
    end
  end
endmodule

// File: rtl/cdec16_top.sv
module cdec16_top
  import cdec_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSN_W-1:0]  in_insn,
  output logic               out_valid,
  output logic [CLS_W-1:0]   out_cls,
  output logic [REG_W-1:0]   out_rd,
  output logic [REG_W-1:0]   out_rs,
  output logic [REG_W-1:0]   out_rm,
  output logic [OP_W-1:0]    out_op,
  output logic [IMM_W-1:0]   out_imm
);
  localparam int PW = CLS_W + 3*REG_W + OP_W + IMM_W;

  logic [NCLS-1:0]  w_hits;
  cls_e             w_cls;
  logic [REG_W-1:0] w_rd, w_rs, w_rm;
  logic [OP_W-1:0]  w_op;
  logic [IMM_W-1:0] w_imm;
  logic [PW-1:0]    w_pack, r_pack;

  cdec_classify u_cls (
    .insn (in_insn),
    .hits (w_hits),
    .cls  (w_cls)
  );

  cdec_fields #(.IMM_W(IMM_W)) u_fld (
    .insn (in_insn),
    .cls  (w_cls),
    .rd   (w_rd),
    .rs   (w_rs),
    .rm   (w_rm),
    .op   (w_op),
    .imm  (w_imm)
  );

  assign w_pack = {w_cls, w_rd, w_rs, w_rm, w_op, w_imm};

  cdec_pipe_reg #(.W(PW)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_in  (in_valid),
    .din     (w_pack),
    .vld_out (out_valid),
    .dout    (r_pack)
  );

  assign {out_cls, out_rd, out_rs, out_rm, out_op, out_imm} = r_pack;
endmodule

// File: rtl/cdec16_chk.sv
module cdec16_chk
  import cdec_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [INSN_W-1:0] in_insn,
  input logic              out_valid,
  input logic [CLS_W-1:0]  out_cls,
  input logic [REG_W-1:0]  out_rd,
  input logic [REG_W-1:0]  out_rs,
  input logic [REG_W-1:0]  out_rm,
  input logic [OP_W-1:0]   out_op,
  input logic [IMM_W-1:0]  out_imm,
  input logic [NCLS-1:0]   hits
);
  p_vld_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_vld_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_cls) && $stable(out_imm) && $stable(out_rd)
                   && $stable(out_rs) && $stable(out_rm) && $stable(out_op)));
  p_bx_carve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_insn[15:8] == 8'h47) |=> out_cls == 5'd7);
  p_misc_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_insn[15:12] == 4'hB && in_insn[11:8] != 4'h0
     && in_insn[10:9] != 2'b10) |=> out_cls == 5'd0);
  p_swi_carve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_insn[15:8] == 8'hDF) |=> out_cls == 5'd18);
  p_cbr_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cls == 5'd17) |-> !out_imm[0]);
  p_undef_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cls == 5'd0) |-> (out_rd == '0 && out_rs == '0 && out_rm == '0
                           && out_op == '0 && out_imm == '0));
  p_one_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hits));
endmodule

bind cdec16_top cdec16_chk #(.IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_insn   (in_insn),
  .out_valid (out_valid),
  .out_cls   (out_cls),
  .out_rd    (out_rd),
  .out_rs    (out_rs),
  .out_rm    (out_rm),
  .out_op    (out_op),
  .out_imm   (out_imm),
  .hits      (w_hits)
);

// File: tb/test_cdec16_top.sv
module test_cdec16_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_insn = '0;
  logic        out_valid;
  logic [4:0]  out_cls;
  logic [3:0]  out_rd, out_rs, out_rm, out_op;
  logic [31:0] out_imm;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cdec16_top i_cdec16_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .out_valid(out_valid), .out_cls(out_cls), .out_rd(out_rd),
    .out_rs(out_rs), .out_rm(out_rm), .out_op(out_op), .out_imm(out_imm)
  );

  // {insn, cls, rd, rs, rm, op, imm}
  localparam int NV = 28;
  localparam logic [68:0] VEC [NV] = '{
    {16'h1234, 5'd1,  4'd4,  4'd0, 4'd6,  4'd2,  32'd8},
    {16'h1D4B, 5'd3,  4'd3,  4'd1, 4'd0,  4'd0,  32'd5},
    {16'h1A9A, 5'd2,  4'd2,  4'd3, 4'd2,  4'd1,  32'd0},
    {16'h2BFF, 5'd4,  4'd3,  4'd0, 4'd0,  4'd1,  32'd255},
    {16'h43D1, 5'd5,  4'd1,  4'd0, 4'd2,  4'd15, 32'd0},
    {16'h46C4, 5'd6,  4'd12, 4'd0, 4'd8,  4'd2,  32'd0},
    {16'h4770, 5'd7,  4'd0,  4'd0, 4'd14, 4'd0,  32'd0},
    {16'h47FF, 5'd7,  4'd0,  4'd0, 4'd15, 4'd0,  32'd0},
    {16'h4DFF, 5'd8,  4'd5,  4'd0, 4'd0,  4'd0,  32'h3FC},
    {16'h5ED3, 5'd9,  4'd3,  4'd2, 4'd3,  4'd7,  32'd0},
    {16'h7FFF, 5'd10, 4'd7,  4'd7, 4'd0,  4'd3,  32'd31},
    {16'h8842, 5'd11, 4'd2,  4'd0, 4'd0,  4'd1,  32'd1},
    {16'h9380, 5'd12, 4'd3,  4'd0, 4'd0,  4'd0,  32'd128},
    {16'hAF01, 5'd13, 4'd7,  4'd0, 4'd0,  4'd1,  32'd1},
    {16'hB0FF, 5'd14, 4'd0,  4'd0, 4'd0,  4'd1,  32'd127},
    {16'hBD0F, 5'd15, 4'd0,  4'd0, 4'd0,  4'd3,  32'd15},
    {16'hB480, 5'd15, 4'd0,  4'd0, 4'd0,  4'd0,  32'd128},
    {16'hB100, 5'd0,  4'd0,  4'd0, 4'd0,  4'd0,  32'd0},
    {16'hBE00, 5'd0,  4'd0,  4'd0, 4'd0,  4'd0,  32'd0},
    {16'hCAA5, 5'd16, 4'd0,  4'd2, 4'd0,  4'd1,  32'd165},
    {16'hD0FE, 5'd17, 4'd0,  4'd0, 4'd0,  4'd0,  32'hFFFF_FFFC},
    {16'hDE7F, 5'd17, 4'd0,  4'd0, 4'd0,  4'd14, 32'd254},
    {16'hDF2A, 5'd18, 4'd0,  4'd0, 4'd0,  4'd0,  32'h2A},
    {16'hE400, 5'd19, 4'd0,  4'd0, 4'd0,  4'd0,  32'hFFFF_F800},
    {16'hE3FF, 5'd19, 4'd0,  4'd0, 4'd0,  4'd0,  32'h7FE},
    {16'hE800, 5'd0,  4'd0,  4'd0, 4'd0,  4'd0,  32'd0},
    {16'hF7FF, 5'd20, 4'd0,  4'd0, 4'd0,  4'd0,  32'h7FF},
    {16'hF801, 5'd21, 4'd0,  4'd0, 4'd0,  4'd0,  32'd1}
  };

  function automatic string req_of(input logic [4:0] c);
    case (c)
      5'd1, 5'd2, 5'd3:                 return "R3";
      5'd4:                             return "R4";
      5'd5, 5'd6, 5'd7:                 return "R5";
      5'd8, 5'd9:                       return "R6";
      5'd10, 5'd11, 5'd12, 5'd13:       return "R7";
      5'd14, 5'd15:                     return "R8";
      5'd16:                            return "R9";
      5'd17, 5'd18:                     return "R10";
      5'd19, 5'd20, 5'd21:              return "R11";
      default:                          return "R12";
    endcase
  endfunction

  task automatic check_all(input string req, input logic v,
                           input logic [52:0] exp);
    logic [52:0] got;
    got = {out_cls, out_rd, out_rs, out_rm, out_op, out_imm};
    n_chk++;
    if (got !== exp || out_valid !== v) begin
      n_err++;
      $display("FAIL %s: got vld=%0b cls=%0d rd=%0d rs=%0d rm=%0d op=%0d imm=%h exp vld=%0b cls=%0d rd=%0d rs=%0d rm=%0d op=%0d imm=%h",
               req, out_valid, out_cls, out_rd, out_rs, out_rm, out_op, out_imm,
               v, exp[52:48], exp[47:44], exp[43:40], exp[39:36], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic present(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = w;
    @(posedge clk);
    #2;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check_all("R1", 1'b0, 53'd0);   // reset state
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      present(VEC[i][68:53]);
      check_all(req_of(VEC[i][52:48]), 1'b1, VEC[i][52:0]);
    end

    // R2: fields hold while in_valid is low, even with a new word on the bus
    present(16'h2BFF);
    @(negedge clk);
    in_valid = 1'b0;
    in_insn  = 16'hDF2A;
    repeat (3) @(posedge clk);
    #2;
    check_all("R2", 1'b0, {5'd4, 4'd3, 4'd0, 4'd0, 4'd1, 32'd255});

    // R2: back-to-back words, each visible one edge later
    present(16'hF801);
    check_all("R11", 1'b1, {5'd21, 4'd0, 4'd0, 4'd0, 4'd0, 32'd1});
    present(16'hD0FE);
    check_all("R2", 1'b1, {5'd17, 4'd0, 4'd0, 4'd0, 4'd0, 32'hFFFF_FFFC});

    // R12: undefined word after a full-field word clears every field
    present(16'h5ED3);
    present(16'hBFFF);
    check_all("R12", 1'b1, 53'd0);

    // R1: reset mid-run clears a loaded decode
    present(16'h7FFF);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #2;
    check_all("R1", 1'b0, 53'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
  end
endmodule